// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Stack-Full Hold-Off

This block sits next to a small 8-bit processor core and decides when the core must take an interrupt. Three event pulses come in: a timer overflow (source 0), an analog-to-digital conversion-done (source 1) and a time-base overflow (source 2). Each source has a sticky request flag and its own enable. A single master enable gates all of them. When an enabled request is pending and the core's return stack has room, the block raises a call request together with that source's vector address.

The core accepts the call with a one-cycle handshake. On that cycle the block clears the served source's flag and the master enable. One cycle later it asks for a single program-counter push, and nothing else is saved. The block also raises a wake signal when the core is asleep and any enabled request is pending. Software reaches the flags and enables through a byte-wide register port with registered read data. A static configuration input lets the conversion-done source share the timer's vector.

Top module: `irq_ctrl`

## Requirements
- R1: A call request is raised only when the master enable and the pending source's own enable are both 1. With the master enable at 0, pending requests raise no call.
- R2: An event pulse on a source sets that source's request flag on the next clock edge. Its enable does not affect this.
- R3: While `stack_full_i` is 1, `call_req_o` is 0 on the following cycle. A held request is presented once the stack frees.
- R4: An accepted call (`svc_ack_i` while `call_req_o` is 1) clears the served source's flag and the master enable on the same edge. Other sources' flags are left unchanged.
- R5: A request flag stays set while its enable is 0. It clears only on service or when software writes 0 to it.
- R6: `wake_o` is 1 one cycle after `sleep_i` is 1 while an enabled flag is set. This does not depend on the master enable.
- R7: Register map with read data valid one cycle after the address. Address 0 holds bit 0 = master enable. Addresses 1, 2 and 3 (sources 0, 1, 2) hold bit 5 = request flag and bit 1 = enable. All other bits read 0.
- R8: With `share_vec_i` = 1, the conversion-done source (source 1) uses vector 0x004.
- R9: Each accepted call gives exactly one `push_o` pulse, one cycle long, on the cycle after acceptance.
- R10: When several enabled requests are pending, source 0 wins over source 1, and source 1 wins over source 2.
- R11: Source vectors are 0x004, 0x008 and 0x00C. `call_req_o` and `call_vec_o` appear one cycle after the request becomes enabled, and `call_req_o` drops on the cycle after acceptance.
- R12: An event and a software write to the same flag in one cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_i | input | 3 | Event pulses, bit 0 timer, bit 1 conversion-done, bit 2 time base |
| share_vec_i | input | 1 | Static option: conversion-done uses the timer vector |
| stack_full_i | input | 1 | Core return stack has no free entry |
| svc_ack_i | input | 1 | Core accepts the presented call |
| sleep_i | input | 1 | Core is in sleep mode |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data |
| call_req_o | output | 1 | Interrupt call request to the core |
| call_vec_o | output | 12 | Vector address of the presented source |
| push_o | output | 1 | Single program-counter push request |
| wake_o | output | 1 | Wake request while sleeping |

## Verification
Suppose a flag is left set after service, or a stale master enable survives an acceptance. The port would show a second call request or a second push within two cycles of the handshake, and a readback of the source register would show bit 5 still at 1. A wrong priority or a wrong vector-select state shows up at once as a mismatched vector on the acceptance cycle. The scoreboard compares these vectors against the order the requirements predict. Hold-off faults show up as a call request one cycle after the stack-full input rises.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NSRC    = 3;
  localparam int unsigned VEC_W   = 12;
  localparam int unsigned VEC_STEP = 4;
  localparam int unsigned SRC_TMR = 0;
  localparam int unsigned SRC_ADC = 1;
  localparam int unsigned SRC_TB  = 2;

  // Vector of a source; the shared option folds conversion-done onto the timer slot.
  function automatic logic [VEC_W-1:0] vec_of(input int unsigned idx, input logic share);
    int unsigned eff;
    eff = (share && idx == SRC_ADC) ? SRC_TMR : idx;
    return VEC_W'((eff + 1) * VEC_STEP);
  endfunction
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic ev_i,
  input  logic clr_i,
  input  logic wr_i,
  input  logic wflag_i,
  input  logic wen_i,
  output logic flag_o,
  output logic en_o
);
  logic flag_q, en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (ev_i)       flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
      else if (wr_i)  flag_q <= wflag_i;
      if (wr_i) en_q <= wen_i;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;

  // R12 / R2: an event always leaves the flag set
  assert_event_sets_R12: assert property (@(posedge clk) disable iff (rst)
    ev_i |=> flag_q);
  // R5: flag survives unless serviced or written to zero
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i && !(wr_i && !wflag_i)) |=> flag_q);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N     = irq_pkg::NSRC,
  parameter int unsigned VEC_W = irq_pkg::VEC_W
) (
  input  logic [N-1:0]     pend_i,
  input  logic             share_i,
  output logic             any_o,
  output logic [N-1:0]     sel_o,
  output logic [VEC_W-1:0] vec_o
);
  logic found;

  always_comb begin
    sel_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i] && !found) begin
        sel_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < N; i++)
      if (sel_o[i]) vec_o = vec_o | irq_pkg::vec_of(i, share_i);
  end

  assign any_o = found;

  // R10: at most one source is presented
  always_comb assert_single_pick_R10: assert ($onehot0(sel_o));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int unsigned N      = irq_pkg::NSRC,
  parameter int unsigned VEC_W  = irq_pkg::VEC_W,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      ev_i,
  input  logic              share_vec_i,
  input  logic              stack_full_i,
  input  logic              svc_ack_i,
  input  logic              sleep_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              call_req_o,
  output logic [VEC_W-1:0]  call_vec_o,
  output logic              push_o,
  output logic              wake_o
);
  localparam int unsigned GEN_BIT  = 0;
  localparam int unsigned EN_BIT   = 1;
  localparam int unsigned FLAG_BIT = 5;

  logic              gen_q, call_q, push_q, wake_q;
  logic [VEC_W-1:0]  vec_q;
  logic [N-1:0]      sel_q, flag, en, pend, clr, wr_src, pick_sel;
  logic [VEC_W-1:0]  pick_vec;
  logic              pick_any, svc;
  logic [DATA_W-1:0] rd_next;

  assign svc  = svc_ack_i && call_q;
  assign pend = flag & en & {N{gen_q}};

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_src
      assign wr_src[g] = reg_wr_i && (reg_addr_i == ADDR_W'(g + 1));
      assign clr[g]    = svc && sel_q[g];
      irq_flag_cell u_cell (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev_i[g]),
        .clr_i   (clr[g]),
        .wr_i    (wr_src[g]),
        .wflag_i (reg_wdata_i[FLAG_BIT]),
        .wen_i   (reg_wdata_i[EN_BIT]),
        .flag_o  (flag[g]),
        .en_o    (en[g])
      );
    end
  endgenerate

  irq_pick #(.N(N), .VEC_W(VEC_W)) u_pick (
    .pend_i  (pend),
    .share_i (share_vec_i),
    .any_o   (pick_any),
    .sel_o   (pick_sel),
    .vec_o   (pick_vec)
  );

  always_comb begin
    rd_next = '0;
    if (reg_addr_i == '0) rd_next[GEN_BIT] = gen_q;
    for (int i = 0; i < N; i++) begin
      if (reg_addr_i == ADDR_W'(i + 1)) begin
        rd_next[FLAG_BIT] = flag[i];
        rd_next[EN_BIT]   = en[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q       <= 1'b0;
      call_q      <= 1'b0;
      vec_q       <= '0;
      sel_q       <= '0;
      push_q      <= 1'b0;
      wake_q      <= 1'b0;
      reg_rdata_o <= '0;
    end else begin
      if (svc) gen_q <= 1'b0;
      else if (reg_wr_i && reg_addr_i == '0) gen_q <= reg_wdata_i[GEN_BIT];
      call_q      <= pick_any && !stack_full_i && !svc;
      vec_q       <= pick_vec;
      sel_q       <= pick_sel;
      push_q      <= svc;
      wake_q      <= sleep_i && |(flag & en);
      reg_rdata_o <= rd_next;
    end
  end

  assign call_req_o = call_q;
  assign call_vec_o = vec_q;
  assign push_o     = push_q;
  assign wake_o     = wake_q;

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata_i[DATA_W-1:FLAG_BIT+1], reg_wdata_i[FLAG_BIT-1:EN_BIT+1]};

  assert_hold_when_full_R3: assert property (@(posedge clk) disable iff (rst)
    stack_full_i |=> !call_req_o);
  assert_service_drops_gen_R4: assert property (@(posedge clk) disable iff (rst)
    svc |=> !gen_q);
  assert_call_needs_gen_R1: assert property (@(posedge clk) disable iff (rst)
    call_req_o |-> $past(gen_q));
  assert_push_follows_ack_R9: assert property (@(posedge clk) disable iff (rst)
    push_o |-> $past(svc));
  assert_push_single_R9: assert property (@(posedge clk) disable iff (rst)
    push_o |=> !push_o);
  assert_wake_needs_sleep_R6: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(sleep_i));
endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ev = '0;
  logic        share = 1'b0, sfull = 1'b0, ack = 1'b0, sleep = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  rdata;
  logic        call_req, push, wake;
  logic [11:0] call_vec;

  int n_cmp = 0, n_bad = 0;
  logic [11:0] expq[$];

  always #5 clk = ~clk;

  irq_ctrl uut (
    .clk(clk), .rst(rst), .ev_i(ev), .share_vec_i(share), .stack_full_i(sfull),
    .svc_ack_i(ack), .sleep_i(sleep), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .call_req_o(call_req),
    .call_vec_o(call_vec), .push_o(push), .wake_o(wake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: compares the presented vector at each acceptance against the scoreboard
  always @(negedge clk) begin
    #1;
    if (ack && call_req) begin
      n_cmp++;
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL R10/R11: actual %0h expected none (unexpected acceptance)", call_vec);
      end else begin
        logic [11:0] e;
        e = expq.pop_front();
        if (call_vec !== e) begin
          n_bad++;
          $display("FAIL R10/R11: actual %0h expected %0h", call_vec, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic pulse(input logic [2:0] m);
    @(negedge clk); ev = m;
    @(negedge clk); ev = '0;
  endtask

  // Driver: pushes the expected vector, then accepts the call
  task automatic serve(input logic [11:0] v);
    expq.push_back(v);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check("R9 push after accept", push, 1);
    check("R11 call drops after accept", call_req, 0);
    @(negedge clk);
    check("R9 single push", push, 0);
    check("R4 no re-call", call_req, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    tick(3); rst = 1'b0; tick(1);
    check("R11 reset call", call_req, 0);
    check("R9 reset push", push, 0);
    check("R6 reset wake", wake, 0);
    rd(2'd0, d); check("R7 reset master", d, 8'h00);

    // R1 / R2: enabled source but master off
    wr(2'd1, 8'h02);
    pulse(3'b001);
    tick(2);
    check("R1 no call without master", call_req, 0);
    rd(2'd1, d); check("R2 timer flag set", d, 8'h22);

    // R11: master on, call with timer vector
    wr(2'd0, 8'h01); tick(1);
    check("R11 call raised", call_req, 1);
    check("R11 timer vector", call_vec, 12'h004);
    serve(12'h004);
    rd(2'd0, d); check("R4 master cleared", d, 8'h00);
    rd(2'd1, d); check("R4 timer flag cleared", d, 8'h02);

    // R10: all three pending together
    wr(2'd2, 8'h02); wr(2'd3, 8'h02);
    pulse(3'b111);
    wr(2'd0, 8'h01); tick(1);
    check("R10 timer first", call_vec, 12'h004);
    serve(12'h004);
    rd(2'd2, d); check("R4 other flag kept", d, 8'h22);
    wr(2'd0, 8'h01); tick(1);
    check("R10 conversion second", call_vec, 12'h008);
    serve(12'h008);
    wr(2'd0, 8'h01); tick(1);
    check("R10 time base third", call_vec, 12'h00C);
    serve(12'h00C);

    // R3: stack full holds off the call
    sfull = 1'b1;
    pulse(3'b100);
    wr(2'd0, 8'h01); tick(3);
    check("R3 held while full", call_req, 0);
    sfull = 1'b0; tick(1);
    check("R3 presented after free", call_req, 1);
    serve(12'h00C);

    // R5: flag sticky with enable off, cleared by write of zero
    wr(2'd1, 8'h00);
    pulse(3'b001);
    rd(2'd1, d); check("R5 flag kept while disabled", d, 8'h20);
    wr(2'd0, 8'h01); tick(2);
    check("R1 no call with source disabled", call_req, 0);
    rd(2'd1, d); check("R5 flag still set", d, 8'h20);
    wr(2'd1, 8'h00);
    rd(2'd1, d); check("R5 write zero clears", d, 8'h00);
    wr(2'd0, 8'h00);

    // R12: event and clearing write in the same cycle
    @(negedge clk); ev = 3'b001; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h00;
    @(negedge clk); ev = '0; reg_wr = 1'b0;
    rd(2'd1, d); check("R12 event wins over write", d, 8'h20);
    wr(2'd1, 8'h00);

    // R6: wake while asleep, master enable off
    sleep = 1'b1;
    pulse(3'b100); tick(1);
    check("R6 wake raised", wake, 1);
    check("R1 no call while master off", call_req, 0);
    wr(2'd3, 8'h02); tick(1);
    check("R6 wake drops after clear", wake, 0);
    sleep = 1'b0;

    // R8: shared vector option
    share = 1'b1;
    pulse(3'b010);
    wr(2'd0, 8'h01); tick(1);
    check("R8 shared vector", call_vec, 12'h004);
    serve(12'h004);
    share = 1'b0;

    // R7: unused bits read as zero
    wr(2'd3, 8'hFF);
    rd(2'd3, d); check("R7 time base layout", d, 8'h22);
    wr(2'd3, 8'h00);
    rd(2'd3, d); check("R7 time base cleared", d, 8'h00);
    wr(2'd0, 8'hFE);
    rd(2'd0, d); check("R7 master layout", d, 8'h00);
    check("R11 scoreboard drained", expq.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule